// File: doc/BRIEF.md
# Masked Dual-Interrupt Status Register Unit

This block is the register and interrupt front end of a card-interface controller. It decodes a simple word-addressed host bus. It holds the configuration registers that the command sequencer and the data engine read. It keeps a sticky event word that software clears by writing ones, and it merges that word with live FIFO flags into a status word. Two independent 32-bit mask registers turn the status word into two interrupt lines. A read-only window at the top of the map returns a fixed eight-byte identification code.

The data engine and the FIFO lie outside the block and connect through strobes. A host read of the FIFO window pops one word. After each successful pop, the block raises a hold flag that freezes further data movement. The hold stays up until the host polls either the status register or the FIFO-count register. That poll drops the hold and sends a one-cycle restart pulse to the engine.

Host accesses are single-cycle and must be word aligned. Read data is combinational in the cycle `bus_rd` is high, and every side effect of the access takes place at the following clock edge. `bus_rd` and `bus_wr` are never high together.

Top module: `ic_status_frontend`

## Requirements
- R1: `irq[i]` is high exactly when the status word ANDed with mask register i is nonzero. Mask 0 is at offset 0x3C and mask 1 at 0x40, both 32 bits wide and readable.
- R2: Sticky status bits 10:0 are set by the matching `evt_set` pulse. A write to 0x38 clears only the sticky bits that are set in wdata[10:0]. When an event and a clear hit the same bit in the same cycle, the event wins.
- R3: Reads of offsets 0xFE0 to 0xFFC return one byte per word, zero-extended, in the order 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R4: A read in the FIFO window 0x80 to 0xBC returns `fifo_rd_word` and pulses `fifo_pop` when the FIFO is not empty. When it is empty, the read returns 0 and does not pop.
- R5: A popping FIFO-window read sets `engine_hold` from the next cycle on. Reads of any other offset, apart from the two polls, leave the hold unchanged.
- R6: A read of 0x34 (status) or 0x48 (FIFO count) while the hold is set clears it at the next edge and pulses `engine_kick` high for exactly one cycle. When the hold is clear, such a read produces no pulse.
- R7: A status read returns the status word as it stood before that cycle's edge, so an event arriving in the same cycle shows up only on a later read.
- R8: Power (0x00), clock (0x04) and data control (0x2C) keep 8 bits, and data length (0x28) keeps 16 bits. Argument (0x08), command (0x0C) and data timer (0x24) keep 32 bits. All of these read back and drive the matching `cfg`, `cmd` and `data` outputs.
- R9: A FIFO-window write pushes wdata (`fifo_push` high, `fifo_wr_word` equal to wdata) only when `data_cnt` is nonzero. Otherwise the write is dropped.
- R10: After reset, every register, both masks, the sticky bits and the hold read as zero, and both interrupts are low.
- R11: Reads of unmapped or misaligned offsets return 0, and writes to them change nothing. This includes writes to the read-only offsets 0x30, 0x34 and 0x48.
- R12: 0x30 returns `data_cnt`, and 0x48 returns `data_cnt` divided by 4 and rounded up.
- R13: Status bits 21:11 mirror `live_flags` and cannot be cleared. Bits 31:22 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, valid while bus_rd is high |
| evt_set | input | 11 | Event pulses that set sticky status bits |
| live_flags | input | 11 | Live FIFO flags shown in status bits 21:11 |
| data_cnt | input | 16 | Remaining byte count from the data engine |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rd_word | input | 32 | Word at the head of the FIFO |
| fifo_pop | output | 1 | Remove the head word |
| fifo_push | output | 1 | Append fifo_wr_word |
| fifo_wr_word | output | 32 | Word to append |
| engine_hold | output | 1 | Freeze data movement |
| engine_kick | output | 1 | One-cycle restart after release |
| cfg_power | output | 8 | Power register |
| cfg_clock | output | 8 | Clock register |
| cmd_arg | output | 32 | Command argument |
| cmd_word | output | 32 | Command register |
| cmd_wr | output | 1 | Command register written this cycle |
| data_timer | output | 32 | Data timeout value |
| data_len | output | 16 | Data length |
| data_ctrl | output | 8 | Data control |
| data_ctrl_wr | output | 1 | Data control written this cycle |
| irq | output | 2 | Masked interrupt lines |

## Verification
The hardest case to reach is the pair of hold and release. A release shows only if a poll comes after a successful pop, with unrelated reads in between that must not release it. The release pulse then lasts only one cycle. The bench sets the FIFO to non-empty, pops one word, reads a non-poll register, and then polls through each of the two release offsets in turn. It samples the hold and restart outputs one edge after each access. A second hard case is an event that lands on the same edge as a clear or a status read. The bench drives the event pulse inside the same bus cycle to force both orderings.

// File: rtl/ic_regs_pkg.sv
// Package: register offsets and the identification code shared by the
// front end. Assumes 12-bit byte offsets on a 32-bit word bus.
package ic_regs_pkg;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int STICKY_W = 11;
    localparam int LIVE_W   = 11;
    localparam int CNT_W    = 16;
    localparam int NUM_IRQ  = 2;

    localparam logic [ADDR_W-1:0] OFF_POWER = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_CLOCK = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_ARG   = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_CMD   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_TIMER = 12'h024;
    localparam logic [ADDR_W-1:0] OFF_LEN   = 12'h028;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h02C;
    localparam logic [ADDR_W-1:0] OFF_DCNT  = 12'h030;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 12'h034;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 12'h038;
    localparam logic [ADDR_W-1:0] OFF_MASK0 = 12'h03C;
    localparam logic [ADDR_W-1:0] OFF_MASK1 = 12'h040;
    localparam logic [ADDR_W-1:0] OFF_FCNT  = 12'h048;

    // One identification byte per word slot of the top window.
    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h81;
            3'd1:    return 8'h11;
            3'd2:    return 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/ic_sticky_status.sv
// Sticky event bits with write-one-to-clear, merged with live flags into
// the status word. Assumes event pulses win over a same-cycle clear.
module ic_sticky_status #(
    parameter int STICKY_W = 11,
    parameter int LIVE_W   = 11,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STICKY_W-1:0] evt_set,
    input  logic                clr_we,
    input  logic [STICKY_W-1:0] clr_bits,
    input  logic [LIVE_W-1:0]   live_flags,
    output logic [DATA_W-1:0]   status_word
);
    localparam int USED_W = STICKY_W + LIVE_W;

    logic [STICKY_W-1:0] sticky_q;
    logic [STICKY_W-1:0] clr_eff;

    // Clear mask only applies while the clear register is written.
    always_comb clr_eff = clr_we ? clr_bits : '0;

    // Keep old bits minus cleared ones, then add new events.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= (sticky_q & ~clr_eff) | evt_set;
    end

    assign status_word = {{(DATA_W-USED_W){1'b0}}, live_flags, sticky_q};

    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((sticky_q & $past(clr_bits & ~evt_set)) == '0));
    assert_event_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((sticky_q & $past(evt_set)) == $past(evt_set)));
endmodule

// File: rtl/ic_irq_mask.sv
// Mask registers, one per interrupt line; a line is high while any
// unmasked status bit is set. Assumes at most one mask written per cycle.
module ic_irq_mask #(
    parameter int DATA_W  = 32,
    parameter int NUM_IRQ = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        mask_we,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [DATA_W-1:0]         status_word,
    output logic [NUM_IRQ*DATA_W-1:0] mask_flat,
    output logic [NUM_IRQ-1:0]        irq
);
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        logic [DATA_W-1:0] mask_q;

        // Load the mask of this line on its write strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)          mask_q <= '0;
            else if (mask_we[i]) mask_q <= wdata;
        end

        assign irq[i] = |(status_word & mask_q);
        assign mask_flat[i*DATA_W +: DATA_W] = mask_q;

        assert_irq_needs_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> (status_word != '0));
        assert_mask_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
            mask_we[i] |=> (mask_q == $past(wdata)));
    end
endmodule

// File: rtl/ic_hold_ctl.sv
// Hold flag that freezes the data engine after a FIFO pop until the host
// polls status or count; the release emits a one-cycle restart pulse.
module ic_hold_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic pop_evt,
    input  logic poll_evt,
    output logic hold_q,
    output logic kick_q
);
    // Release on poll has priority; otherwise a pop arms the hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            kick_q <= 1'b0;
        end else begin
            kick_q <= poll_evt & hold_q;
            if (poll_evt)     hold_q <= 1'b0;
            else if (pop_evt) hold_q <= 1'b1;
        end
    end

    assert_hold_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_evt && !poll_evt) |=> hold_q);
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_evt && hold_q) |=> (!hold_q && kick_q));
    assert_kick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        kick_q |=> !kick_q);
endmodule

// File: rtl/ic_status_frontend.sv
// Register front end: host decode, configuration registers, status and
// interrupt masking, identification window and the FIFO hold rule.
// Assumes aligned single-cycle accesses, never a read and write together.
module ic_status_frontend
    import ic_regs_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [STICKY_W-1:0] evt_set,
    input  logic [LIVE_W-1:0]   live_flags,
    input  logic [CNT_W-1:0]    data_cnt,
    input  logic                fifo_empty,
    input  logic [DATA_W-1:0]   fifo_rd_word,
    output logic                fifo_pop,
    output logic                fifo_push,
    output logic [DATA_W-1:0]   fifo_wr_word,
    output logic                engine_hold,
    output logic                engine_kick,
    output logic [7:0]          cfg_power,
    output logic [7:0]          cfg_clock,
    output logic [DATA_W-1:0]   cmd_arg,
    output logic [DATA_W-1:0]   cmd_word,
    output logic                cmd_wr,
    output logic [DATA_W-1:0]   data_timer,
    output logic [CNT_W-1:0]    data_len,
    output logic [7:0]          data_ctrl,
    output logic                data_ctrl_wr,
    output logic [NUM_IRQ-1:0]  irq
);
    localparam int FCNT_W = CNT_W + 1;

    logic                      aligned, hit_fifo, hit_id, poll_rd;
    logic [DATA_W-1:0]         status_word;
    logic [NUM_IRQ*DATA_W-1:0] mask_flat;
    logic [NUM_IRQ-1:0]        mask_we;
    logic [FCNT_W-1:0]         fifo_words;

    // Address classes shared by read and write decode.
    always_comb begin
        aligned  = (bus_addr[1:0] == 2'b00);
        hit_fifo = aligned && (bus_addr[11:6] == 6'b000010);
        hit_id   = aligned && (bus_addr[11:5] == 7'h7F);
        poll_rd  = bus_rd && (bus_addr == OFF_STAT || bus_addr == OFF_FCNT);
    end

    // Configuration registers, truncated to their kept widths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_power  <= '0;
            cfg_clock  <= '0;
            cmd_arg    <= '0;
            cmd_word   <= '0;
            data_timer <= '0;
            data_len   <= '0;
            data_ctrl  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFF_POWER: cfg_power  <= bus_wdata[7:0];
                OFF_CLOCK: cfg_clock  <= bus_wdata[7:0];
                OFF_ARG:   cmd_arg    <= bus_wdata;
                OFF_CMD:   cmd_word   <= bus_wdata;
                OFF_TIMER: data_timer <= bus_wdata;
                OFF_LEN:   data_len   <= bus_wdata[CNT_W-1:0];
                OFF_CTRL:  data_ctrl  <= bus_wdata[7:0];
                default:   ;
            endcase
        end
    end

    // Write strobes toward the sequencer, the data engine and the masks.
    always_comb begin
        cmd_wr       = bus_wr && (bus_addr == OFF_CMD);
        data_ctrl_wr = bus_wr && (bus_addr == OFF_CTRL);
        mask_we[0]   = bus_wr && (bus_addr == OFF_MASK0);
        mask_we[1]   = bus_wr && (bus_addr == OFF_MASK1);
        fifo_push    = bus_wr && hit_fifo && (data_cnt != '0);
        fifo_wr_word = bus_wdata;
        fifo_pop     = bus_rd && hit_fifo && !fifo_empty;
    end

    // Word count of the remaining bytes, rounded up.
    always_comb fifo_words = ({1'b0, data_cnt} + FCNT_W'(3)) >> 2;

    ic_sticky_status #(.STICKY_W(STICKY_W), .LIVE_W(LIVE_W), .DATA_W(DATA_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_set    (evt_set),
        .clr_we     (bus_wr && (bus_addr == OFF_CLR)),
        .clr_bits   (bus_wdata[STICKY_W-1:0]),
        .live_flags (live_flags),
        .status_word(status_word)
    );

    ic_irq_mask #(.DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_we    (mask_we),
        .wdata      (bus_wdata),
        .status_word(status_word),
        .mask_flat  (mask_flat),
        .irq        (irq)
    );

    ic_hold_ctl u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .pop_evt (fifo_pop),
        .poll_evt(poll_rd),
        .hold_q  (engine_hold),
        .kick_q  (engine_kick)
    );

    // Read mux; status is the pre-edge value, so a release never alters it.
    always_comb begin
        bus_rdata = '0;
        if (hit_fifo) begin
            if (!fifo_empty) bus_rdata = fifo_rd_word;
        end else if (hit_id) begin
            bus_rdata = {{(DATA_W-8){1'b0}}, id_byte(bus_addr[4:2])};
        end else begin
            case (bus_addr)
                OFF_POWER: bus_rdata = {{(DATA_W-8){1'b0}}, cfg_power};
                OFF_CLOCK: bus_rdata = {{(DATA_W-8){1'b0}}, cfg_clock};
                OFF_ARG:   bus_rdata = cmd_arg;
                OFF_CMD:   bus_rdata = cmd_word;
                OFF_TIMER: bus_rdata = data_timer;
                OFF_LEN:   bus_rdata = {{(DATA_W-CNT_W){1'b0}}, data_len};
                OFF_CTRL:  bus_rdata = {{(DATA_W-8){1'b0}}, data_ctrl};
                OFF_DCNT:  bus_rdata = {{(DATA_W-CNT_W){1'b0}}, data_cnt};
                OFF_STAT:  bus_rdata = status_word;
                OFF_MASK0: bus_rdata = mask_flat[0 +: DATA_W];
                OFF_MASK1: bus_rdata = mask_flat[DATA_W +: DATA_W];
                OFF_FCNT:  bus_rdata = {{(DATA_W-FCNT_W){1'b0}}, fifo_words};
                default:   bus_rdata = '0;
            endcase
        end
    end

    assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit_fifo && fifo_empty) |-> (bus_rdata == '0 && !fifo_pop));
    assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (data_cnt == '0)) |-> !fifo_push);
    assert_id_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit_id) |-> (bus_rdata[DATA_W-1:8] == '0));
    assert_status_top_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[DATA_W-1:STICKY_W+LIVE_W] == '0));
endmodule

// File: tb/ic_status_frontend_bench.sv
`timescale 1ns/1ps
module ic_status_frontend_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [10:0] evt_set = '0, live_flags = '0;
    logic [15:0] data_cnt = '0;
    logic        fifo_empty = 1'b1;
    logic [31:0] fifo_rd_word = '0;
    logic        fifo_pop, fifo_push, engine_hold, engine_kick, cmd_wr, data_ctrl_wr;
    logic [31:0] fifo_wr_word, cmd_arg, cmd_word, data_timer;
    logic [7:0]  cfg_power, cfg_clock, data_ctrl;
    logic [15:0] data_len;
    logic [1:0]  irq;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // Shadow state the expected values are computed from.
    logic [31:0] sh_power, sh_clock, sh_arg, sh_cmd, sh_timer, sh_len, sh_ctrl, sh_m0, sh_m1;
    logic [10:0] sh_sticky;
    logic [7:0]  id_exp [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    always #2 clk = ~clk;

    ic_status_frontend u_ic_status_frontend (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic popped);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        #1; d = bus_rdata; popped = fifo_pop;
        @(posedge clk); #1; bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] v, output logic pushed);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        #1; pushed = fifo_push;
        @(posedge clk); #1; bus_wr = 1'b0;
    endtask

    task automatic pulse_evt(input logic [10:0] e);
        @(negedge clk); evt_set = e;
        @(posedge clk); #1; evt_set = '0;
    endtask

    function automatic logic [31:0] status_exp();
        return {10'b0, live_flags, sh_sticky};
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        if (a >= 12'hFE0) return {24'h0, id_exp[a[4:2]]};
        if (a >= 12'h080 && a <= 12'h0BC) return 32'h0;
        case (a)
            12'h000: return sh_power;
            12'h004: return sh_clock;
            12'h008: return sh_arg;
            12'h00C: return sh_cmd;
            12'h024: return sh_timer;
            12'h028: return sh_len;
            12'h02C: return sh_ctrl;
            12'h030: return {16'h0, data_cnt};
            12'h034: return status_exp();
            12'h03C: return sh_m0;
            12'h040: return sh_m1;
            12'h048: return (32'(data_cnt) + 32'd3) / 32'd4;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        if (a >= 12'hFE0 && a[1:0] == 2'b00) return "R3";
        if (a >= 12'h080 && a <= 12'h0BC && a[1:0] == 2'b00) return "R4";
        if (a == 12'h030 || a == 12'h048) return "R12";
        if (a == 12'h034) return "R13";
        if (exp_read(a) != 0) return "R8";
        return "R11";
    endfunction

    task automatic sweep_reads(input bit at_reset);
        logic [31:0] d; logic p;
        for (int w = 0; w < 1024; w++) begin
            logic [11:0] a;
            a = 12'(w * 4);
            bus_read(a, d, p);
            if (at_reset && !(a >= 12'hFE0)) chk("R10", d, 32'h0);
            else chk(tag_of(a), d, exp_read(a));
        end
        bus_read(12'h001, d, p); chk("R11", d, 32'h0);
    endtask

    task automatic wr_cfg(input logic [11:0] a, input logic [31:0] v);
        logic p;
        bus_write(a, v, p);
        case (a)
            12'h000: sh_power = v & 32'hFF;
            12'h004: sh_clock = v & 32'hFF;
            12'h008: sh_arg   = v;
            12'h00C: sh_cmd   = v;
            12'h024: sh_timer = v;
            12'h028: sh_len   = v & 32'hFFFF;
            12'h02C: sh_ctrl  = v & 32'hFF;
            12'h03C: sh_m0    = v;
            12'h040: sh_m1    = v;
            default: ;
        endcase
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d; logic p;
        {sh_power, sh_clock, sh_arg, sh_cmd, sh_timer, sh_len, sh_ctrl, sh_m0, sh_m1} = '0;
        sh_sticky = '0;
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;

        // R10: reset state at the ports and through every read.
        chk("R10", {30'b0, irq}, 32'h0);
        chk("R10", {31'b0, engine_hold}, 32'h0);
        sweep_reads(1'b1);

        // R8: widths of the configuration registers.
        wr_cfg(12'h000, 32'hFFFF_FFA5); wr_cfg(12'h004, 32'h1234_5677);
        wr_cfg(12'h008, 32'hDEAD_BEEF); wr_cfg(12'h00C, 32'h0000_0451);
        wr_cfg(12'h024, 32'hFFFF_FFFF); wr_cfg(12'h028, 32'hABCD_9876);
        wr_cfg(12'h02C, 32'hFFFF_FF3C);
        chk("R8", {24'h0, cfg_power}, 32'hA5);
        chk("R8", {16'h0, data_len}, 32'h9876);
        chk("R8", {24'h0, data_ctrl}, 32'h3C);
        chk("R8", cmd_word, 32'h451);

        // Near-exhaustive decode sweep with non-trivial live state.
        wr_cfg(12'h03C, 32'h8000_0001); wr_cfg(12'h040, 32'h0012_3400);
        live_flags = 11'h5A3;
        for (int c = 0; c < 3; c++) begin
            data_cnt = (c == 0) ? 16'h1235 : (c == 1) ? 16'h0004 : 16'hFFFF;
            #1; sweep_reads(1'b0);
        end
        // R11: writes to every unmapped or read-only offset change nothing.
        data_cnt = 16'h0007;
        for (int w = 0; w < 1024; w++) begin
            logic [11:0] a;
            a = 12'(w * 4);
            if (!(a inside {12'h000, 12'h004, 12'h008, 12'h00C, 12'h024, 12'h028,
                            12'h02C, 12'h038, 12'h03C, 12'h040}) &&
                !(a >= 12'h080 && a <= 12'h0BC))
                bus_write(a, 32'hFFFF_FFFF, p);
        end
        bus_write(12'h081, 32'hFFFF_FFFF, p); chk("R11", {31'b0, p}, 32'h0);
        sweep_reads(1'b0);

        // R1, R2: per-bit sticky set, masking on both lines, selective clear.
        live_flags = '0;
        for (int b = 0; b < 11; b++) begin
            wr_cfg(12'h03C, 32'h1 << b); wr_cfg(12'h040, 32'h0);
            chk("R1", {30'b0, irq}, 32'h0);
            pulse_evt(11'(1 << b)); sh_sticky[b] = 1'b1;
            chk("R1", {30'b0, irq}, 32'h1);
            wr_cfg(12'h03C, ~(32'h1 << b)); wr_cfg(12'h040, 32'h1 << b);
            chk("R1", {30'b0, irq}, 32'h2);
            bus_write(12'h038, ~(32'h1 << b), p);
            bus_read(12'h034, d, p); chk("R2", d, status_exp());
            bus_write(12'h038, 32'hFFFF_F800 | (32'h1 << b), p); sh_sticky[b] = 1'b0;
            bus_read(12'h034, d, p); chk("R2", d, status_exp());
            chk("R1", {30'b0, irq}, 32'h0);
        end
        // R13: live bits mask into interrupts and survive a full clear.
        for (int j = 0; j < 11; j++) begin
            wr_cfg(12'h03C, 32'h0); wr_cfg(12'h040, 32'h800 << j);
            live_flags = 11'(1 << j); #1;
            chk("R13", {30'b0, irq}, 32'h2);
            bus_write(12'h038, 32'hFFFF_FFFF, p);
            bus_read(12'h034, d, p); chk("R13", d, 32'h800 << j);
        end
        live_flags = '0;
        // R2: event and clear on the same bit and edge, event wins.
        @(negedge clk); bus_wr = 1'b1; bus_addr = 12'h038; bus_wdata = 32'h7FF; evt_set = 11'h404;
        @(posedge clk); #1; bus_wr = 1'b0; evt_set = '0; sh_sticky = 11'h404;
        bus_read(12'h034, d, p); chk("R2", d, 32'h404);
        // R7: event in the status-read cycle appears only on a later read.
        @(negedge clk); bus_rd = 1'b1; bus_addr = 12'h034; evt_set = 11'h010;
        #1; d = bus_rdata;
        @(posedge clk); #1; bus_rd = 1'b0; evt_set = '0;
        chk("R7", d, 32'h404);
        sh_sticky = 11'h414;
        bus_read(12'h034, d, p); chk("R7", d, 32'h414);

        // R9: FIFO write rejected at zero count, accepted otherwise.
        data_cnt = '0;
        bus_write(12'h0A0, 32'h1111_2222, p); chk("R9", {31'b0, p}, 32'h0);
        data_cnt = 16'd5;
        @(negedge clk); bus_wr = 1'b1; bus_addr = 12'h0BC; bus_wdata = 32'h3333_4444;
        #1; chk("R9", {31'b0, fifo_push}, 32'h1); chk("R9", fifo_wr_word, 32'h3333_4444);
        @(posedge clk); #1; bus_wr = 1'b0;

        // R4: empty read returns zero, no pop, no hold.
        fifo_empty = 1'b1; fifo_rd_word = 32'hCAFE_0001;
        bus_read(12'h080, d, p);
        chk("R4", d, 32'h0); chk("R4", {31'b0, p}, 32'h0);
        chk("R5", {31'b0, engine_hold}, 32'h0);

        // R5, R6: pop arms the hold, each poll offset releases it once.
        for (int k = 0; k < 2; k++) begin
            logic [11:0] poll_a;
            poll_a = (k == 0) ? 12'h034 : 12'h048;
            fifo_empty = 1'b0;
            bus_read(12'h09C, d, p);
            chk("R4", d, 32'hCAFE_0001); chk("R4", {31'b0, p}, 32'h1);
            chk("R5", {31'b0, engine_hold}, 32'h1);
            fifo_empty = 1'b1;
            bus_read(12'h02C, d, p);
            chk("R5", {31'b0, engine_hold}, 32'h1);
            chk("R6", {31'b0, engine_kick}, 32'h0);
            bus_read(poll_a, d, p);
            chk("R6", {30'b0, engine_hold, engine_kick}, 32'h1);
            @(posedge clk); #1;
            chk("R6", {31'b0, engine_kick}, 32'h0);
            bus_read(poll_a, d, p);
            chk("R6", {30'b0, engine_hold, engine_kick}, 32'h0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule